// File: doc/BRIEF.md
# I2C Target Controller with Clock-Hold Control

This block is the target (slave) side of an I2C bus. It samples the SCL and SDA lines, finds START, repeated START and STOP conditions, and shifts bytes in and out. It answers to a 7-bit or a 10-bit own address. It can also answer the general call address, or answer every address when the catch-all mode is on. It pulls SDA and SCL low through two open-drain enable outputs. It talks to a local host through a control register, a transmit-byte load strobe, and received-byte and event strobes.

A clock-hold bit in the control register decides whether the block keeps SCL low between bytes. Hardware clears this bit before every byte the block must send, so the host has time to supply data. When the hold-enable field is set, hardware also clears it after every received data byte. The write rules for the clock-hold bit depend on the hold-enable field: when hold-enable is 1, software may write 0 or 1; when it is 0, software can only set the bit.

Top module: `i2cs_slave`

## Requirements
- R1: After reset the control word reads 0x20: clock-hold bit (bit 5) is 1 and all other bits are 0. Neither line is driven. Control bits 4:0 always read back the last value written. Bit layout: bit 0 enable, bit 1 ten-bit mode, bit 2 catch-all, bit 3 general-call enable, bit 4 hold-enable, bit 5 clock-hold.
- R2: While the enable bit is 0, sda_oe and scl_oe stay 0 and bus traffic raises no strobes.
- R3: In 7-bit mode, an address byte whose bits 7:1 equal own_addr[6:0] is acknowledged and pulses addr_hit. Any other non-zero address is not acknowledged.
- R4: In ten-bit mode, a header byte 11110 followed by own_addr[9:8] and a write bit (0) is acknowledged when those two bits match. The next byte is acknowledged when it equals own_addr[7:0]. A repeated START with the header and a read bit (1) is acknowledged and enters transmit only after such a full match. After a STOP, or after a 7-bit-style address, it is not acknowledged.
- R5: With catch-all set, every address byte is acknowledged, whatever own_addr holds.
- R6: Address 0x00 is acknowledged and pulses gc_hit when general-call enable is 1. It is not acknowledged when general-call enable is 0 (and catch-all is 0).
- R7: Each data byte written by the bus master is acknowledged and presented MSB first on rx_data with a one-cycle rx_valid.
- R8: Before every byte to be sent (after a read address ACK, and after a master ACK), hardware clears the clock-hold bit and pulses tx_req. SCL is then held low until the host sets the bit. The byte loaded through tx_we is sent MSB first.
- R9: After a master NACK of a sent byte, the block releases SDA and ignores the bus until the next START. No new tx_req is raised.
- R10: With hold-enable 1, hardware clears the clock-hold bit after the ACK of every received data byte, and SCL is held low. Software writes of 0 and of 1 both take effect.
- R11: With hold-enable 0, a software write of 0 to the clock-hold bit is ignored, and no hold follows a received data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word write value |
| ctl_rdata | output | 6 | Control word read value |
| own_addr | input | 10 | Own address (7-bit mode uses bits 6:0) |
| tx_we | input | 1 | Load strobe for the next byte to send |
| tx_data | input | 8 | Byte to send |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data updated |
| addr_hit | output | 1 | One-cycle pulse: an address byte was acknowledged |
| gc_hit | output | 1 | One-cycle pulse: general call acknowledged |
| tx_req | output | 1 | One-cycle pulse: a byte to send is needed |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench targets the moments when the clock-hold bit changes.
- A design that missed the clear before a sent byte would let the master clock out stale data.
- A design that cleared the bit after address bytes, or with hold-enable off, would hang the bus.
- A design that accepted a zero write with hold-enable off would stretch the clock with nothing to release it.

For ten-bit addressing, the bench sends a read header both after a full match and after a STOP. A design that kept its match across the STOP would answer the second one. The bench also clocks a full byte after a master NACK, where a slave that stayed in transmit would drive data bits onto SDA.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int CNT_W   = $clog2(BYTE_W + 2);

  // control word layout
  localparam int CTL_W     = 6;
  localparam int CTL_EN    = 0;
  localparam int CTL_A10   = 1;
  localparam int CTL_PROM  = 2;
  localparam int CTL_GCEN  = 3;
  localparam int CTL_STREN = 4;
  localparam int CTL_REL   = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << CTL_REL;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR2, S_RX, S_TX} st_e;

  typedef struct packed {
    logic ack;
    logic gc;
    logic set10;
    st_e  nxt;
  } adec_t;

  // first byte after a START
  function automatic adec_t decode_first(input logic [BYTE_W-1:0] b,
                                         input logic [ADDR_W-1:0] own,
                                         input logic a10, input logic prom,
                                         input logic gcen, input logic m10);
    adec_t d;
    d = '0;
    if (b == '0) begin
      d.ack = gcen | prom;
      d.gc  = gcen;
      d.nxt = S_RX;
    end else if (a10 && b[7:3] == 5'b11110) begin
      if (!b[0]) begin
        d.ack = prom | (b[2:1] == own[9:8]);
        d.nxt = S_ADDR2;
      end else begin
        d.ack = prom | (m10 && b[2:1] == own[9:8]);
        d.nxt = S_TX;
      end
    end else begin
      d.ack = prom | (!a10 && b[7:1] == own[6:0]);
      d.nxt = b[0] ? S_TX : S_RX;
    end
    return d;
  endfunction

  // low byte of a ten-bit address
  function automatic adec_t decode_second(input logic [BYTE_W-1:0] b,
                                          input logic [ADDR_W-1:0] own,
                                          input logic prom);
    adec_t d;
    d       = '0;
    d.ack   = prom | (b == own[7:0]);
    d.set10 = d.ack;
    d.nxt   = S_RX;
    return d;
  endfunction
endpackage

// File: rtl/i2cs_sync.sv
`timescale 1ns/1ps
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] q,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else if (clr) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], din[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign q[g]    = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev;
    assign fall[g] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/i2cs_ctl.sv
`timescale 1ns/1ps
module i2cs_ctl
  import i2cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             hw_clr,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] wr_val;

  always_comb begin
    wr_val = wdata;
    // hold-enable decides whether a zero may land in the clock-hold bit
    wr_val[CTL_REL] = q[CTL_STREN] ? wdata[CTL_REL] : (q[CTL_REL] | wdata[CTL_REL]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= CTL_RESET;
    end else begin
      if (we) q <= wr_val;
      if (hw_clr) q[CTL_REL] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_engine.sv
`timescale 1ns/1ps
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              a10,
  input  logic              prom,
  input  logic              gcen,
  input  logic              stren,
  input  logic              tx_we,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              busy,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              tx_req,
  output logic              clr_rel
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACKC = CNT_W'(BYTE_W + 1);

  st_e               state, nxt;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_drive, mack, matched10;
  adec_t             dec;
  logic              start_det, stop_det;

  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;

  always_comb begin
    case (state)
      S_ADDR:  dec = decode_first(shreg, own_addr, a10, prom, gcen, matched10);
      S_ADDR2: dec = decode_second(shreg, own_addr, prom);
      default: begin
        dec     = '0;
        dec.ack = 1'b1;
        dec.nxt = S_RX;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; nxt <= S_IDLE; bitcnt <= '0; shreg <= '0;
      ack_drive <= 1'b0; mack <= 1'b0; matched10 <= 1'b0; rx_data <= '0;
      rx_valid <= 1'b0; addr_hit <= 1'b0; gc_hit <= 1'b0; tx_req <= 1'b0; clr_rel <= 1'b0;
    end else if (clr) begin
      state <= S_IDLE; nxt <= S_IDLE; bitcnt <= '0; shreg <= '0;
      ack_drive <= 1'b0; mack <= 1'b0; matched10 <= 1'b0; rx_data <= '0;
      rx_valid <= 1'b0; addr_hit <= 1'b0; gc_hit <= 1'b0; tx_req <= 1'b0; clr_rel <= 1'b0;
    end else begin
      rx_valid <= 1'b0; addr_hit <= 1'b0; gc_hit <= 1'b0; tx_req <= 1'b0; clr_rel <= 1'b0;
      if (start_det) begin
        state <= S_ADDR; bitcnt <= '0; ack_drive <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; ack_drive <= 1'b0; matched10 <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_ADDR2, S_RX: begin
            if (scl_rise && bitcnt < LAST) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST) begin
              if (dec.ack) begin
                ack_drive <= 1'b1;
                bitcnt    <= ACKC;
                nxt       <= dec.nxt;
                if (dec.set10) matched10 <= 1'b1;
              end else begin
                state     <= S_IDLE;
                matched10 <= 1'b0;
              end
              if (state == S_RX) begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
              end else begin
                addr_hit <= dec.ack;
                gc_hit   <= dec.ack & dec.gc;
              end
            end else if (scl_fall && bitcnt == ACKC) begin
              ack_drive <= 1'b0;
              bitcnt    <= '0;
              state     <= nxt;
              if (nxt == S_TX) begin
                tx_req  <= 1'b1;
                clr_rel <= 1'b1;
              end else if (state == S_RX && stren) begin
                clr_rel <= 1'b1;
              end
            end
          end
          S_TX: begin
            if (tx_we && bitcnt == '0) shreg <= tx_data;
            if (scl_fall && bitcnt < LAST) begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b1};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_rise && bitcnt == LAST) begin
              mack <= ~sda_s;
            end else if (scl_fall && bitcnt == LAST) begin
              if (mack) begin
                bitcnt  <= '0;
                tx_req  <= 1'b1;
                clr_rel <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (state == S_TX && bitcnt < LAST) ? ~shreg[BYTE_W-1] : ack_drive;
  assign busy   = (state != S_IDLE);
endmodule

// File: rtl/i2cs_slave.sv
`timescale 1ns/1ps
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_we,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addr_hit,
  output logic              gc_hit,
  output logic              tx_req,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [CTL_W-1:0] ctl_q;
  logic [1:0]       line_q, line_rise, line_fall;
  logic             en, eng_busy, eng_clr_rel, eng_sda_oe;

  assign en = ctl_q[CTL_EN];

  i2cs_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
    .hw_clr(eng_clr_rel), .q(ctl_q)
  );

  // line 0 = SCL, line 1 = SDA
  i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(~en), .din({sda_in, scl_in}),
    .q(line_q), .rise(line_rise), .fall(line_fall)
  );

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(~en),
    .scl_s(line_q[0]), .sda_s(line_q[1]),
    .scl_rise(line_rise[0]), .scl_fall(line_fall[0]),
    .sda_rise(line_rise[1]), .sda_fall(line_fall[1]),
    .own_addr(own_addr), .a10(ctl_q[CTL_A10]), .prom(ctl_q[CTL_PROM]),
    .gcen(ctl_q[CTL_GCEN]), .stren(ctl_q[CTL_STREN]),
    .tx_we(tx_we), .tx_data(tx_data),
    .sda_oe(eng_sda_oe), .busy(eng_busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .addr_hit(addr_hit), .gc_hit(gc_hit), .tx_req(tx_req), .clr_rel(eng_clr_rel)
  );

  assign ctl_rdata = ctl_q;
  assign sda_oe    = en & eng_sda_oe;
  assign scl_oe    = en & ~ctl_q[CTL_REL] & eng_busy & ~line_q[0];
endmodule

// File: rtl/i2cs_slave_chk.sv
`timescale 1ns/1ps
module i2cs_slave_chk
  import i2cs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             busy,
  input logic             clr_rel,
  input logic             tx_req,
  input logic             gc_hit,
  input logic             addr_hit,
  input logic             rx_valid
);
  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[CTL_EN] |-> (!sda_oe && !scl_oe));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !ctl_rdata[CTL_REL]);

  // R10
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rel |=> !ctl_rdata[CTL_REL]);

  // R11
  zero_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_rdata[CTL_STREN] && ctl_rdata[CTL_REL] && !clr_rel) |=> ctl_rdata[CTL_REL]);

  // R8
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (!ctl_rdata[CTL_REL] && busy));

  // R6
  gc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> (ctl_rdata[CTL_GCEN] && addr_hit));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, addr_hit, tx_req}));

  // R9
  sda_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(eng_busy), .clr_rel(eng_clr_rel),
  .tx_req(tx_req), .gc_hit(gc_hit), .addr_hit(addr_hit), .rx_valid(rx_valid)
);

// File: tb/tb_i2cs_slave.sv
`timescale 1ns/1ps
module tb_i2cs_slave;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_rdata;
  logic [9:0] own_addr = 10'h2A5;
  logic       tx_we = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic       rx_valid, addr_hit, gc_hit, tx_req, scl_oe, sda_oe;
  logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  wire        scl_bus = !(m_scl_lo || scl_oe);
  wire        sda_bus = !(m_sda_lo || sda_oe);

  int n_chk = 0, n_fail = 0;
  int n_txreq = 0, n_gc = 0, n_addr = 0;
  bit done = 1'b0;
  logic [4:0] model_sw = '0;
  logic [7:0] exp_rx[$];

  always #2.5 clk = ~clk;

  i2cs_slave dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .own_addr(own_addr), .tx_we(tx_we), .tx_data(tx_data), .rx_data(rx_data),
    .rx_valid(rx_valid), .addr_hit(addr_hit), .gc_hit(gc_hit), .tx_req(tx_req),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ctl_rdata[4:0] == model_sw, "R1 control fields", ctl_rdata[4:0], model_sw);
      if (!model_sw[0]) chk(!sda_oe && !scl_oe, "R2 lines quiet", {sda_oe, scl_oe}, 0);
      if (rx_valid) begin
        if (exp_rx.size() == 0) chk(1'b0, "R7 unexpected byte", rx_data, 0);
        else begin
          automatic logic [7:0] e = exp_rx.pop_front();
          chk(rx_data == e, "R7 received byte", rx_data, e);
        end
      end
      if (tx_req) n_txreq++;
      if (gc_hit) n_gc++;
      if (addr_hit) n_addr++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [5:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); #1;
    ctl_we = 1'b0;
    model_sw = v[4:0];
    cyc(2);
  endtask

  task automatic tx_load(input logic [7:0] v);
    @(negedge clk);
    tx_we = 1'b1; tx_data = v;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic scl_up;
    int t;
    t = 0;
    m_scl_lo = 1'b0;
    while (!scl_bus && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 4000) chk(1'b0, "R8 clock held too long", 0, 1);
  endtask

  task automatic bit_out(input logic b);
    m_sda_lo = !b;
    cyc(H); scl_up(); cyc(H);
    m_scl_lo = 1'b1; cyc(4);
  endtask

  task automatic bit_in(output logic b);
    m_sda_lo = 1'b0;
    cyc(H); scl_up(); cyc(H/2);
    b = sda_bus;
    cyc(H/2);
    m_scl_lo = 1'b1; cyc(4);
  endtask

  task automatic m_start;
    m_sda_lo = 1'b0;
    cyc(H); scl_up(); cyc(H);
    m_sda_lo = 1'b1; cyc(H);
    m_scl_lo = 1'b1; cyc(4);
  endtask

  task automatic m_stop;
    m_sda_lo = 1'b1;
    cyc(H); scl_up(); cyc(H);
    m_sda_lo = 1'b0; cyc(H);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(s);
    ack = !s;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_in(s);
      v[i] = s;
    end
    bit_out(!ack);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    int tq, gq, aq;
    cyc(10);
    rst_n = 1'b1;
    cyc(2);
    // R1
    chk(ctl_rdata == 6'h20, "R1 reset word", ctl_rdata, 6'h20);
    chk(!sda_oe && !scl_oe, "R1 reset lines", {sda_oe, scl_oe}, 0);

    // R2: disabled block ignores its own address
    m_start(); wr_byte(8'h4A, a); m_stop();
    chk(!a, "R2 no ACK while off", a, 0);
    chk(n_addr == 0, "R2 no strobe while off", n_addr, 0);

    // R3, R7, R11: 7-bit write, no hold-enable
    ctl_write(6'h21);
    m_start(); wr_byte(8'h4A, a);
    chk(a, "R3 own address ACK", a, 1);
    exp_rx.push_back(8'h3C); wr_byte(8'h3C, a);
    chk(a, "R7 data ACK", a, 1);
    exp_rx.push_back(8'h81); wr_byte(8'h81, a);
    cyc(H);
    chk(!scl_oe && ctl_rdata[5], "R11 no hold after data", {scl_oe, ctl_rdata[5]}, 1);
    m_stop();
    m_start(); wr_byte(8'h4C, a); m_stop();
    chk(!a, "R3 other address NACK", a, 0);

    // R11: zero write ignored
    ctl_write(6'h01);
    chk(ctl_rdata[5], "R11 zero write ignored", ctl_rdata[5], 1);

    // R6: general call
    ctl_write(6'h21);
    m_start(); wr_byte(8'h00, a); m_stop();
    chk(!a, "R6 general call off NACK", a, 0);
    ctl_write(6'h29);
    gq = n_gc;
    m_start(); wr_byte(8'h00, a);
    chk(a && n_gc == gq + 1, "R6 general call ACK and strobe", {a, 8'(n_gc - gq)}, 9'h101);
    exp_rx.push_back(8'h55); wr_byte(8'h55, a); m_stop();

    // R5: catch-all
    ctl_write(6'h25);
    m_start(); wr_byte(8'h9E, a);
    chk(a, "R5 any address ACK", a, 1);
    exp_rx.push_back(8'h11); wr_byte(8'h11, a); m_stop();

    // R10: hold-enable on
    ctl_write(6'h31);
    m_start(); wr_byte(8'h4A, a); cyc(H);
    chk(!scl_oe, "R10 no hold after address", scl_oe, 0);
    exp_rx.push_back(8'h77); wr_byte(8'h77, a); cyc(H);
    chk(scl_oe && !ctl_rdata[5], "R10 hold after data", {scl_oe, ctl_rdata[5]}, 2'b10);
    ctl_write(6'h31);
    chk(!scl_oe && ctl_rdata[5], "R10 write one releases", {scl_oe, ctl_rdata[5]}, 2'b01);
    ctl_write(6'h11);
    chk(scl_oe && !ctl_rdata[5], "R10 write zero holds", {scl_oe, ctl_rdata[5]}, 2'b10);
    ctl_write(6'h31);
    m_stop();

    // R8, R9: 7-bit read
    ctl_write(6'h21);
    tq = n_txreq;
    m_start(); wr_byte(8'h4B, a); cyc(H);
    chk(a && n_txreq == tq + 1, "R8 read address ACK and request", {a, 8'(n_txreq - tq)}, 9'h101);
    chk(scl_oe && !ctl_rdata[5], "R8 hold before first byte", {scl_oe, ctl_rdata[5]}, 2'b10);
    tx_load(8'hC3); ctl_write(6'h21);
    rd_byte(b, 1'b1);
    chk(b == 8'hC3, "R8 first byte", b, 8'hC3);
    cyc(H);
    chk(scl_oe && !ctl_rdata[5] && n_txreq == tq + 2, "R8 hold before next byte",
        {scl_oe, ctl_rdata[5]}, 2'b10);
    tx_load(8'h5A); ctl_write(6'h21);
    rd_byte(b, 1'b0);
    chk(b == 8'h5A, "R8 second byte", b, 8'h5A);
    cyc(H);
    chk(!scl_oe && ctl_rdata[5], "R9 no hold after NACK", {scl_oe, ctl_rdata[5]}, 2'b01);
    rd_byte(b, 1'b0);
    chk(b == 8'hFF && n_txreq == tq + 2, "R9 bus ignored after NACK", b, 8'hFF);
    m_stop();

    // R4: ten-bit
    ctl_write(6'h23);
    aq = n_addr;
    m_start(); wr_byte(8'hF4, a);
    chk(a, "R4 header ACK", a, 1);
    wr_byte(8'hA5, a);
    chk(a && n_addr == aq + 2, "R4 low byte ACK", {a, 8'(n_addr - aq)}, 9'h102);
    exp_rx.push_back(8'h66); wr_byte(8'h66, a);
    m_start(); wr_byte(8'hF5, a);
    chk(a, "R4 read header after match ACK", a, 1);
    tx_load(8'h99); ctl_write(6'h23);
    rd_byte(b, 1'b0);
    chk(b == 8'h99, "R4 ten-bit read byte", b, 8'h99);
    m_stop();
    m_start(); wr_byte(8'hF5, a); m_stop();
    chk(!a, "R4 read header after STOP NACK", a, 0);
    m_start(); wr_byte(8'hF4, a); wr_byte(8'hA6, a); m_stop();
    chk(!a, "R4 wrong low byte NACK", a, 0);
    m_start(); wr_byte(8'h4A, a); m_stop();
    chk(!a, "R4 7-bit address in ten-bit mode NACK", a, 0);

    cyc(20);
    chk(exp_rx.size() == 0, "R7 all bytes seen", exp_rx.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule